// File: doc/BRIEF.md
# Programmable Clock Frequency Generator Bank

A bank of six frequency generators inside one fast system clock domain. Three source clocks (CPU clock, auxiliary PLL, second auxiliary PLL) arrive as single-cycle enable strobes. Each generator picks one source, counts its strobes, and emits a divided strobe plus a square-wave output. Either output can be gated off. The outputs are registered.

Software programs the bank through two 32-bit control registers. Each register holds three 10-bit generator fields, with generator k of a register at bits 10k+9 to 10k. Writes carry a per-bit mask, so one field can be changed without touching its neighbours. The parameter `EXT` picks the field layout:

- **Legacy layout** (`EXT=0`): an explicit source bit and enable bit, with even division only.
- **Extended layout** (`EXT=1`): a 2-bit source code where zero means off. Bit 30 of each register selects whether the divide factor steps by one or by two for the three generators in that register.

Top module: `fgen_bank`

## Requirements
- R1: After synchronous reset both registers read as zero and every generator's strobe and square outputs are low.
- R2: A write stores `wdata` only in the bits where `wmask` is 1; all other register bits keep their value. `reg_rdata` shows the register selected by `reg_addr` at the previous clock edge.
- R3: Legacy layout: field bit 0 selects the source (0 = CPU strobe, 1 = auxiliary strobe), bits 9:2 hold N, and the divide factor is (N+1)*2. Register bit 30 has no effect.
- R4: Legacy layout: field bit 1 is the enable. While it is 0, the strobe and square outputs are low from the clock after the write onward.
- R5: Extended layout: field bits 1:0 are a source code (1 = second auxiliary, 2 = CPU, 3 = auxiliary). Code 0 disables the generator whatever bits 9:2 hold.
- R6: Extended layout: with register bit 30 set, the divide factor is N+1 (1 to 256). With bit 30 clear, it is (N+1)*2.
- R7: For a divide factor of 1, both outputs copy the selected source strobe one clock later.
- R8: For a factor F of 2 or more, the square output is high after each of the first ceil(F/2) strobes of a period and low after the rest.
- R9: Any change of a generator's source, enable or factor restarts its strobe count at zero. The first output strobe then comes after F further source strobes.
- R10: An enabled generator emits one output strobe, one clock after each F-th source strobe, and no strobe at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select for write and read |
| reg_wdata | input | 32 | Write data |
| reg_wmask | input | 32 | Per-bit write mask |
| reg_rdata | output | 32 | Registered read data |
| src_stb | input | 3 | Source strobes: bit 0 CPU, bit 1 auxiliary, bit 2 second auxiliary |
| gen_stb | output | 6 | Divided output strobes, one per generator |
| gen_sq | output | 6 | Square-wave outputs, one per generator |

## Verification
The assertions assume that reset is held from time zero until the first clock edge. They also assume that source strobes are plain single-cycle levels sampled at the clock edge, with no relation between sources.

The bench changes a configuration only while the source strobes are held off. It restarts them no earlier than one clock after the restart edge. This keeps the expected counts exact: floor(S/F) output strobes and ceil(S/F) square rises for S source strobes.

The bench generates strobes with fixed periods of 1, 2 and 3 cycles. Each source therefore produces a different count over the same window, so a wrong source selection changes the result.

// File: rtl/fgen_pkg.sv
package fgen_pkg;
  localparam int REG_W     = 32;
  localparam int FIELD_W   = 10;
  localparam int DIV_W     = 8;
  localparam int LIM_W     = DIV_W + 1;
  localparam int SRC_N     = 3;
  localparam int SCALE_BIT = 30;

  typedef enum logic [1:0] {
    SRC_CPU  = 2'd0,
    SRC_AUX  = 2'd1,
    SRC_AUX2 = 2'd2
  } src_e;

  // lim holds divide factor minus one
  typedef struct packed {
    logic             en;
    src_e             src;
    logic [LIM_W-1:0] lim;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/fgen_regs.sv
module fgen_regs #(
  parameter int NREG  = 2,
  parameter int REG_W = 32,
  localparam int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic [AW-1:0]              addr,
  input  logic [REG_W-1:0]           wdata,
  input  logic [REG_W-1:0]           wmask,
  output logic [REG_W-1:0]           rdata,
  output logic [NREG-1:0][REG_W-1:0] regs_o
);
  logic [NREG-1:0][REG_W-1:0] regs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
      rdata  <= '0;
    end else begin
      if (wr) regs_q[addr] <= (regs_q[addr] & ~wmask) | (wdata & wmask);
      rdata <= regs_q[addr];
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/fgen_decode.sv
module fgen_decode
  import fgen_pkg::*;
#(
  parameter bit EXT = 1'b1
) (
  input  logic [FIELD_W-1:0] field,
  input  logic               scale,
  output cfg_t               cfg
);
  logic [DIV_W-1:0] n;
  assign n = field[FIELD_W-1:2];

  generate
    if (EXT) begin : g_ext
      always_comb begin
        cfg.en = |field[1:0];
        unique case (field[1:0])
          2'd1:    cfg.src = SRC_AUX2;
          2'd3:    cfg.src = SRC_AUX;
          default: cfg.src = SRC_CPU;
        endcase
        cfg.lim = scale ? {1'b0, n} : {n, 1'b1};
      end
    end else begin : g_legacy
      logic unused_scale;
      assign unused_scale = scale;
      always_comb begin
        cfg.en  = field[1];
        cfg.src = field[0] ? SRC_AUX : SRC_CPU;
        cfg.lim = {n, 1'b1};
      end
    end
  endgenerate
endmodule

// File: rtl/fgen_div.sv
module fgen_div
  import fgen_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cfg_t cfg,
  input  logic in_stb,
  output logic out_stb,
  output logic out_sq
);
  logic [LIM_W-1:0] cnt_q;
  cfg_t             last_q;
  logic             wrap;

  assign wrap = (cnt_q == cfg.lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      last_q  <= '0;
      out_stb <= 1'b0;
      out_sq  <= 1'b0;
    end else begin
      last_q <= cfg;
      if (!cfg.en || (cfg != last_q)) begin
        cnt_q   <= '0;
        out_stb <= 1'b0;
        out_sq  <= 1'b0;
      end else if (cfg.lim == '0) begin
        cnt_q   <= '0;
        out_stb <= in_stb;
        out_sq  <= in_stb;
      end else begin
        out_stb <= in_stb & wrap;
        if (in_stb) begin
          out_sq <= (cnt_q <= (cfg.lim >> 1));
          cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fgen_bank.sv
module fgen_bank
  import fgen_pkg::*;
#(
  parameter bit EXT         = 1'b1,
  parameter int NUM_GEN     = 6,
  parameter int GEN_PER_REG = 3,
  localparam int NREG       = NUM_GEN / GEN_PER_REG,
  localparam int AW         = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic [REG_W-1:0]   reg_wmask,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [SRC_N-1:0]   src_stb,
  output logic [NUM_GEN-1:0] gen_stb,
  output logic [NUM_GEN-1:0] gen_sq
);
  logic [NREG-1:0][REG_W-1:0] regs_flat;
  logic [NUM_GEN-1:0]         gen_en;
  logic [NUM_GEN-1:0]         sel_stb;
  logic [NUM_GEN*CFG_W-1:0]   cfg_flat;

  fgen_regs #(.NREG(NREG), .REG_W(REG_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .wmask  (reg_wmask),
    .rdata  (reg_rdata),
    .regs_o (regs_flat)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    localparam int RI = g / GEN_PER_REG;
    localparam int KI = g % GEN_PER_REG;
    cfg_t cfg_g;

    fgen_decode #(.EXT(EXT)) u_dec (
      .field (regs_flat[RI][KI*FIELD_W +: FIELD_W]),
      .scale (regs_flat[RI][SCALE_BIT]),
      .cfg   (cfg_g)
    );

    assign sel_stb[g] = src_stb[cfg_g.src];
    assign gen_en[g]  = cfg_g.en;
    assign cfg_flat[g*CFG_W +: CFG_W] = cfg_g;

    fgen_div u_div (
      .clk     (clk),
      .rst     (rst),
      .cfg     (cfg_g),
      .in_stb  (sel_stb[g]),
      .out_stb (gen_stb[g]),
      .out_sq  (gen_sq[g])
    );
  end
endmodule

// File: rtl/fgen_bank_chk.sv
module fgen_bank_chk
  import fgen_pkg::*;
#(
  parameter int NUM_GEN = 6,
  parameter int NREG    = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       reg_wr,
  input logic [NUM_GEN-1:0]         gen_stb,
  input logic [NUM_GEN-1:0]         gen_sq,
  input logic [NUM_GEN-1:0]         gen_en,
  input logic [NUM_GEN-1:0]         sel_stb,
  input logic [NUM_GEN*CFG_W-1:0]   cfg_flat,
  input logic [NREG-1:0][REG_W-1:0] regs_flat
);
  // R1: the first cycle after reset shows quiet outputs
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gen_stb == '0 && gen_sq == '0));

  // R2: registers move only on a write
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> $stable(regs_flat));

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    // R4 / R5: a disabled generator is silent one clock later
    a_r4_off_quiet: assert property (@(posedge clk) disable iff (rst)
      !gen_en[g] |=> (!gen_stb[g] && !gen_sq[g]));

    // R10: an output strobe needs an enabled source strobe one clock earlier
    a_r10_stb_cause: assert property (@(posedge clk) disable iff (rst)
      gen_stb[g] |-> ($past(sel_stb[g]) && $past(gen_en[g])));

    // R9: a configuration change restarts with both outputs low
    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
      (cfg_flat[g*CFG_W +: CFG_W] != $past(cfg_flat[g*CFG_W +: CFG_W]))
      |=> (!gen_stb[g] && !gen_sq[g]));
  end
endmodule

bind fgen_bank fgen_bank_chk #(.NUM_GEN(NUM_GEN), .NREG(NREG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .gen_stb   (gen_stb),
  .gen_sq    (gen_sq),
  .gen_en    (gen_en),
  .sel_stb   (sel_stb),
  .cfg_flat  (cfg_flat),
  .regs_flat (regs_flat)
);

// File: tb/tb_fgen_bank.sv
module tb_fgen_bank;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_l = 1'b0, wr_x = 1'b0;
  logic [0:0]  addr = '0;
  logic [31:0] wdata = '0, wmask = '0;
  logic [31:0] rdata_l, rdata_x;
  logic [2:0]  src_stb = '0;
  logic [5:0]  stb_l, sq_l, stb_x, sq_x;

  always #(CLK_PERIOD/2) clk = ~clk;

  fgen_bank #(.EXT(1'b0)) dut (
    .clk(clk), .rst(rst), .reg_wr(wr_l), .reg_addr(addr), .reg_wdata(wdata),
    .reg_wmask(wmask), .reg_rdata(rdata_l), .src_stb(src_stb),
    .gen_stb(stb_l), .gen_sq(sq_l));

  fgen_bank #(.EXT(1'b1)) dut_x (
    .clk(clk), .rst(rst), .reg_wr(wr_x), .reg_addr(addr), .reg_wdata(wdata),
    .reg_wmask(wmask), .reg_rdata(rdata_x), .src_stb(src_stb),
    .gen_stb(stb_x), .gen_sq(sq_x));

  int checks = 0, errors = 0;
  logic [31:0] shadow [2][2];

  // strobe driver state
  bit run = 0;
  int ph = 0;
  int in_cnt [3];
  // monitor state
  bit tgt_ext = 0;
  int tgt_g = 0;
  int stb_cnt = 0, sq_rise = 0, sq_high = 0;
  bit sq_prev = 0;

  initial begin
    forever begin
      @(negedge clk);
      src_stb[0] = run;
      src_stb[1] = run && (ph % 2 == 0);
      src_stb[2] = run && (ph % 3 == 0);
      for (int i = 0; i < 3; i++) if (src_stb[i]) in_cnt[i]++;
      if (run) ph++;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      begin
        bit s, q;
        s = tgt_ext ? stb_x[tgt_g] : stb_l[tgt_g];
        q = tgt_ext ? sq_x[tgt_g]  : sq_l[tgt_g];
        if (s) stb_cnt++;
        if (q) sq_high++;
        if (q && !sq_prev) sq_rise++;
        sq_prev = q;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input bit ext, input int r, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    addr  = r[0:0];
    wdata = d;
    wmask = m;
    if (ext) wr_x = 1'b1; else wr_l = 1'b1;
    shadow[ext][r] = (shadow[ext][r] & ~m) | (d & m);
    @(negedge clk);
    wr_l = 1'b0;
    wr_x = 1'b0;
  endtask

  task automatic wr_field(input bit ext, input int g, input logic [9:0] f);
    int sh;
    sh = 10 * (g % 3);
    do_write(ext, g / 3, {22'b0, f} << sh, 32'h3FF << sh);
  endtask

  task automatic set_scale(input bit ext, input int r, input bit s);
    do_write(ext, r, {1'b0, s, 30'b0}, 32'h4000_0000);
  endtask

  task automatic read_reg(input bit ext, input int r, output logic [31:0] v);
    @(negedge clk);
    addr = r[0:0];
    @(negedge clk);
    v = ext ? rdata_x : rdata_l;
  endtask

  task automatic clear_counts();
    stb_cnt = 0; sq_rise = 0; sq_high = 0; sq_prev = 0;
    for (int i = 0; i < 3; i++) in_cnt[i] = 0;
    ph = 0;
  endtask

  task automatic window(input int n);
    @(posedge clk);
    clear_counts();
    run = 1;
    repeat (n) @(posedge clk);
    run = 0;
    repeat (4) @(posedge clk);
  endtask

  typedef struct packed {
    logic       ext;
    logic [2:0] g;
    logic [9:0] fld;
    logic       scl;
    logic [1:0] src;
    logic [9:0] f;
    logic [11:0] cyc;
  } vec_t;

  // R3, R5, R6, R7, R10 vectors: layout, generator, field, scale bit, source, factor, cycles
  localparam vec_t VECS [10] = '{
    '{1'b0, 3'd0, 10'h002, 1'b0, 2'd0, 10'd2,   12'd40},
    '{1'b0, 3'd1, 10'h00B, 1'b0, 2'd1, 10'd6,   12'd60},
    '{1'b0, 3'd4, 10'h012, 1'b0, 2'd0, 10'd10,  12'd55},
    '{1'b0, 3'd5, 10'h006, 1'b1, 2'd0, 10'd4,   12'd30},
    '{1'b1, 3'd0, 10'h002, 1'b1, 2'd0, 10'd1,   12'd20},
    '{1'b1, 3'd2, 10'h00B, 1'b1, 2'd1, 10'd3,   12'd60},
    '{1'b1, 3'd3, 10'h011, 1'b0, 2'd2, 10'd10,  12'd90},
    '{1'b1, 3'd4, 10'h01A, 1'b1, 2'd0, 10'd7,   12'd50},
    '{1'b1, 3'd5, 10'h3FE, 1'b1, 2'd0, 10'd256, 12'd600},
    '{1'b0, 3'd2, 10'h3FE, 1'b0, 2'd0, 10'd512, 12'd1100}
  };

  bit done = 0;

  initial begin
    logic [31:0] v;
    for (int e = 0; e < 2; e++) for (int r = 0; r < 2; r++) shadow[e][r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk((stb_l | sq_l | stb_x | sq_x) == '0, "R1 outputs low", int'(stb_l | sq_l | stb_x | sq_x), 0);
    for (int e = 0; e < 2; e++)
      for (int r = 0; r < 2; r++) begin
        read_reg(e[0], r, v);
        chk(v == '0, "R1 register zero", int'(v), 0);
      end

    // vector table
    foreach (VECS[i]) begin
      int inn, f;
      set_scale(VECS[i].ext, VECS[i].g / 3, VECS[i].scl);
      wr_field(VECS[i].ext, VECS[i].g, VECS[i].fld);
      repeat (2) @(negedge clk);
      tgt_ext = VECS[i].ext;
      tgt_g   = VECS[i].g;
      window(VECS[i].cyc);
      inn = in_cnt[VECS[i].src];
      f   = VECS[i].f;
      chk(stb_cnt == inn / f, "R10 strobe count (R3/R5/R6)", stb_cnt, inn / f);
      if (f == 1)
        chk(sq_high == inn, "R7 factor one square", sq_high, inn);
      else
        chk(sq_rise == (inn + f - 1) / f, "R8 square rises", sq_rise, (inn + f - 1) / f);
    end

    // R2 readback of masked field writes
    for (int e = 0; e < 2; e++)
      for (int r = 0; r < 2; r++) begin
        read_reg(e[0], r, v);
        chk(v == shadow[e][r], "R2 readback", int'(v), int'(shadow[e][r]));
      end

    // R4 legacy disable while strobes run
    tgt_ext = 0; tgt_g = 0;
    wr_field(1'b0, 0, 10'h006);
    repeat (2) @(negedge clk);
    @(posedge clk);
    clear_counts();
    run = 1;
    repeat (12) @(posedge clk);
    chk(stb_cnt > 0, "R4 running before disable", stb_cnt, 1);
    wr_field(1'b0, 0, 10'h004);
    @(posedge clk);
    clear_counts();
    repeat (20) @(posedge clk);
    run = 0;
    repeat (3) @(posedge clk);
    chk(stb_cnt == 0 && sq_high == 0, "R4 disabled quiet", stb_cnt + sq_high, 0);

    // R5 extended code zero disables, divisor bits set
    tgt_ext = 1; tgt_g = 0;
    wr_field(1'b1, 0, 10'h3FC);
    repeat (2) @(negedge clk);
    window(20);
    chk(stb_cnt == 0 && sq_high == 0, "R5 code zero off", stb_cnt + sq_high, 0);

    // R8 odd factor 3 square shape
    tgt_ext = 1; tgt_g = 1;
    set_scale(1'b1, 0, 1'b1);
    wr_field(1'b1, 1, 10'h00A);
    repeat (2) @(negedge clk);
    window(9);
    chk(sq_high == 6, "R8 odd factor high cycles", sq_high, 6);
    chk(stb_cnt == 3, "R10 factor three strobes", stb_cnt, 3);

    // R8 even factor 4 square shape, legacy
    tgt_ext = 0; tgt_g = 1;
    wr_field(1'b0, 1, 10'h006);
    repeat (2) @(negedge clk);
    window(8);
    chk(sq_high == 4, "R8 even factor high cycles", sq_high, 4);

    // R9 restart on factor change
    tgt_ext = 1; tgt_g = 1;
    wr_field(1'b1, 1, 10'h00E);
    repeat (2) @(negedge clk);
    window(2);
    chk(stb_cnt == 0, "R9 partial period", stb_cnt, 0);
    wr_field(1'b1, 1, 10'h012);
    repeat (2) @(negedge clk);
    window(4);
    chk(stb_cnt == 0, "R9 count restarted", stb_cnt, 0);
    window(1);
    chk(stb_cnt == 1, "R9 strobe after full period", stb_cnt, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule